// File: doc/BRIEF.md
# GPIO Bank with Level and Edge Interrupts

This block is one bank of general-purpose pins behind a simple register bus. Each pin has a sampled input, an output value and a drive enable. Software can pick one of two interrupt sources for any pin. The level source compares the synchronized pin against a per-pin polarity. The edge source watches for a chosen transition and keeps an event bit set until software clears it.

Each source has its own per-pin mask. All masked sources are OR-ed into one bank status bit. A one-bit top-level mask gates that bit onto the single interrupt output. The bus writes on the clock edge when select and write are both high, and it returns read data in the same cycle.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The registers are at these byte offsets: input data 0x00 (read-only), output value 0x04, drive enable 0x08, level polarity 0x10, level mask 0x14, edge events 0x18, edge mask 0x1C, edge select 0x24, bank status 0x40 (bit 0, read-only) and bank mask 0x44 (bit 0). Every writable register reads back the value last written to it.
- R2: After reset, every writable register reads 0 and `irq_o` is low. A read of any offset not listed in R1 (for example 0x0C or 0x20) returns 0.
- R3: A pin passes through two synchronizing flops. A change on `pad_di` shows up in input data after the second rising edge, and not after the first.
- R4: `pad_do` carries the output value register and `pad_oe` carries the drive enable register. A pin whose enable bit is 1 drives; a pin whose enable bit is 0 is released.
- R5: The level source of a pin is (synchronized input XOR polarity) AND level mask. A polarity bit of 0 means active high and 1 means active low. The level source is never latched.
- R6: An edge-select bit of 0 makes a rising edge set the event bit; a bit of 1 makes a falling edge set it. The bit becomes visible on the third rising edge after the pad changes. A transition in the other direction sets nothing.
- R7: Event bits latch even when their edge-mask bit is 0. Only masked event bits contribute to the bank status.
- R8: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged.
- R9: If an edge is detected in the same cycle that a clearing write hits the same bit, the bit stays set.
- R10: Bank status bit 0 is the OR of all masked level and edge sources, and a write to it has no effect. `irq_o` is high only when that status bit and bank mask bit 0 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, same cycle |
| pad_di | input | NPIN | Raw pin inputs |
| pad_do | output | NPIN | Output values toward the pad cells |
| pad_oe | output | NPIN | Per-pin drive enable |
| irq_o | output | 1 | Bank interrupt |

## Verification
The hardest case to reach from the ports is a hardware edge and a software clear landing on the same event bit in the same cycle. The bench reaches it by counting the synchronizer and edge-register latency from the pad change. It issues the clearing write so that it commits on exactly the third rising edge. Level behaviour is driven from a vector table that sweeps polarity and mask against pin patterns, including the top pin. Edge tests then cover both edge directions, the masked-but-latched case and write-zero-keeps.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam logic [7:0] OFS_DIN   = 8'h00;
  localparam logic [7:0] OFS_DOUT  = 8'h04;
  localparam logic [7:0] OFS_OE    = 8'h08;
  localparam logic [7:0] OFS_LPOL  = 8'h10;
  localparam logic [7:0] OFS_LMSK  = 8'h14;
  localparam logic [7:0] OFS_EVT   = 8'h18;
  localparam logic [7:0] OFS_EMSK  = 8'h1C;
  localparam logic [7:0] OFS_ESEL  = 8'h24;
  localparam logic [7:0] OFS_TSTAT = 8'h40;
  localparam logic [7:0] OFS_TMSK  = 8'h44;

  // masked level source per pin
  function automatic logic [31:0] level_src(input logic [31:0] din,
                                            input logic [31:0] pol,
                                            input logic [31:0] msk);
    return (din ^ pol) & msk;
  endfunction

  // transition hits: sel=0 rising, sel=1 falling
  function automatic logic [31:0] edge_hits(input logic [31:0] cur,
                                            input logic [31:0] prev,
                                            input logic [31:0] sel);
    return (cur & ~prev & ~sel) | (~cur & prev & sel);
  endfunction

  // event update: clear first, new hit wins
  function automatic logic [31:0] evt_next(input logic [31:0] evt,
                                           input logic [31:0] hit,
                                           input logic [31:0] clr);
    return (evt & ~clr) | hit;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] sel_fall,
  input  logic [W-1:0] clr,
  output logic [W-1:0] hit,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev;
  logic [31:0]  hit_full;
  logic [31:0]  nxt_full;

  assign hit_full = edge_hits(32'(cur), 32'(prev), 32'(sel_fall));
  assign hit      = hit_full[W-1:0];
  assign nxt_full = evt_next(32'(evt), 32'(hit), 32'(clr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      evt  <= '0;
    end else begin
      prev <= cur;
      evt  <= nxt_full[W-1:0];
    end
  end

  // R6 / R9: a detected edge always leaves its bit set
  p_edge_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((evt & $past(hit)) == $past(hit)));

  // R8: a clear without a competing edge empties the bit
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~hit) != '0) |=> ((evt & $past(clr & ~hit)) == '0));

  // R8: bits neither hit nor cleared keep their value
  p_evt_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((evt ^ $past(evt)) & ~$past(hit | clr)) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pad_di,
  output logic [NPIN-1:0] pad_do,
  output logic [NPIN-1:0] pad_oe,
  output logic            irq_o
);
  logic [NPIN-1:0] din_s;
  logic [NPIN-1:0] r_dout, r_oe, r_lpol, r_lmsk, r_emsk, r_esel;
  logic            r_tmsk;
  logic [NPIN-1:0] evt, edge_hit, evt_clr;
  logic [NPIN-1:0] pend_level, pend_edge, pend_all;
  logic [31:0]     lvl_full;
  logic            gpio_src;
  logic            wr_go;

  gpio_sync #(.W(NPIN), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_di), .q(din_s)
  );

  assign wr_go   = bus_sel & bus_wr;
  assign evt_clr = (wr_go && bus_addr == AW'(OFS_EVT)) ? bus_wdata[NPIN-1:0] : '0;

  gpio_edge_latch #(.W(NPIN)) u_edge (
    .clk(clk), .rst_n(rst_n), .cur(din_s), .sel_fall(r_esel),
    .clr(evt_clr), .hit(edge_hit), .evt(evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_dout <= '0; r_oe <= '0; r_lpol <= '0; r_lmsk <= '0;
      r_emsk <= '0; r_esel <= '0; r_tmsk <= 1'b0;
    end else if (wr_go) begin
      if (bus_addr == AW'(OFS_DOUT)) r_dout <= bus_wdata[NPIN-1:0];
      if (bus_addr == AW'(OFS_OE))   r_oe   <= bus_wdata[NPIN-1:0];
      if (bus_addr == AW'(OFS_LPOL)) r_lpol <= bus_wdata[NPIN-1:0];
      if (bus_addr == AW'(OFS_LMSK)) r_lmsk <= bus_wdata[NPIN-1:0];
      if (bus_addr == AW'(OFS_EMSK)) r_emsk <= bus_wdata[NPIN-1:0];
      if (bus_addr == AW'(OFS_ESEL)) r_esel <= bus_wdata[NPIN-1:0];
      if (bus_addr == AW'(OFS_TMSK)) r_tmsk <= bus_wdata[0];
    end
  end

  assign lvl_full   = level_src(32'(din_s), 32'(r_lpol), 32'(r_lmsk));
  assign pend_level = lvl_full[NPIN-1:0];
  assign pend_edge  = evt & r_emsk;
  assign pend_all   = pend_level | pend_edge;
  assign gpio_src   = |pend_all;
  assign irq_o      = gpio_src & r_tmsk;

  assign pad_do = r_dout;
  assign pad_oe = r_oe;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        AW'(OFS_DIN):   bus_rdata = DW'(din_s);
        AW'(OFS_DOUT):  bus_rdata = DW'(r_dout);
        AW'(OFS_OE):    bus_rdata = DW'(r_oe);
        AW'(OFS_LPOL):  bus_rdata = DW'(r_lpol);
        AW'(OFS_LMSK):  bus_rdata = DW'(r_lmsk);
        AW'(OFS_EVT):   bus_rdata = DW'(evt);
        AW'(OFS_EMSK):  bus_rdata = DW'(r_emsk);
        AW'(OFS_ESEL):  bus_rdata = DW'(r_esel);
        AW'(OFS_TSTAT): bus_rdata = DW'(gpio_src);
        AW'(OFS_TMSK):  bus_rdata = DW'(r_tmsk);
        default:        bus_rdata = '0;
      endcase
    end
  end

  // R10: the interrupt line needs a live pending source
  p_irq_has_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_all != '0));

  // R7: an unmasked edge event cannot raise the line by itself
  p_edge_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_level == '0 && (evt & r_emsk) == '0) |-> !irq_o);

  // R2: holes in the map read as zero
  p_hole_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == AW'(8'h0C) || bus_addr == AW'(8'h20)))
      |-> (bus_rdata == '0));
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int NPIN = 32;
  localparam int AW   = 8;
  localparam int DW   = 32;

  typedef struct packed {
    logic [31:0] pins;
    logic [31:0] pol;
    logic [31:0] msk;
    logic        exp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 1'b1},
    '{32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 1'b0},
    '{32'h0000_0000, 32'h0000_0001, 32'h0000_0001, 1'b1},
    '{32'h0000_00F0, 32'h0000_0000, 32'h0000_000F, 1'b0},
    '{32'h0000_00F0, 32'h0000_00FF, 32'h0000_000F, 1'b1},
    '{32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 1'b1}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_sel, bus_wr;
  logic [AW-1:0]   bus_addr;
  logic [DW-1:0]   bus_wdata, bus_rdata;
  logic [NPIN-1:0] pad_di, pad_do, pad_oe;
  logic            irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_di(pad_di), .pad_do(pad_do), .pad_oe(pad_oe), .irq_o(irq_o)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; pad_di = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R2: reset values and holes
    chk_reg("R2 lpol", 8'h10, 32'h0);
    chk_reg("R2 emsk", 8'h1C, 32'h0);
    chk_reg("R2 tmsk", 8'h44, 32'h0);
    chk_reg("R2 hole 0x0C", 8'h0C, 32'h0);
    chk_reg("R2 hole 0x20", 8'h20, 32'h0);
    chk("R2 irq", 32'(irq_o), 32'h0);

    // R1: readback of writable registers
    wr(8'h24, 32'h0000_0F00);
    chk_reg("R1 esel", 8'h24, 32'h0000_0F00);
    wr(8'h24, 32'h0);
    wr(8'h1C, 32'h1234_5678);
    chk_reg("R1 emsk", 8'h1C, 32'h1234_5678);
    wr(8'h1C, 32'h0);

    // R4: output path
    wr(8'h04, 32'h0000_00A5);
    wr(8'h08, 32'h0000_000F);
    chk("R4 pad_do", 32'(pad_do), 32'h0000_00A5);
    chk("R4 pad_oe", 32'(pad_oe), 32'h0000_000F);
    chk_reg("R1 dout", 8'h04, 32'h0000_00A5);

    // R3: two-flop latency on input data
    pad_di = 32'h0000_0055;
    tick();
    chk_reg("R3 after one edge", 8'h00, 32'h0);
    tick();
    chk_reg("R3 after two edges", 8'h00, 32'h0000_0055);

    // R5 / R10: level vectors
    wr(8'h44, 32'h1);
    foreach (VEC[i]) begin
      wr(8'h10, VEC[i].pol);
      wr(8'h14, VEC[i].msk);
      pad_di = VEC[i].pins;
      tick(); tick();
      chk_reg("R3 din", 8'h00, VEC[i].pins);
      chk_reg("R10 status", 8'h40, 32'(VEC[i].exp));
      chk("R5 irq level", 32'(irq_o), 32'(VEC[i].exp));
    end

    // R5: not latched, source goes away with the pin
    pad_di = 32'h0;
    tick(); tick();
    chk("R5 unlatched", 32'(irq_o), 32'h0);

    // edge setup
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0);
    tick(); tick(); tick();
    wr(8'h18, 32'hFFFF_FFFF);
    chk_reg("R8 all cleared", 8'h18, 32'h0);

    // R6: pin3 rising, pin4 falling-select
    wr(8'h24, 32'h0000_0010);
    pad_di = 32'h0000_0018;
    tick(); tick();
    chk_reg("R6 not yet", 8'h18, 32'h0);
    tick();
    chk_reg("R6 rising sets", 8'h18, 32'h0000_0008);
    pad_di = 32'h0000_0008;
    tick(); tick(); tick();
    chk_reg("R6 falling sets", 8'h18, 32'h0000_0018);

    // R7: latched but masked
    chk("R7 masked no irq", 32'(irq_o), 32'h0);
    wr(8'h1C, 32'h0000_0008);
    chk("R7 unmasked irq", 32'(irq_o), 32'h1);

    // R10: status read-only, mask gates line
    wr(8'h40, 32'h0);
    chk_reg("R10 status read-only", 8'h40, 32'h1);
    wr(8'h44, 32'h0);
    chk("R10 bank mask off", 32'(irq_o), 32'h0);
    chk_reg("R10 status kept", 8'h40, 32'h1);
    wr(8'h44, 32'h1);

    // R8: write 0 keeps, write 1 clears
    wr(8'h18, 32'h0);
    chk_reg("R8 zero keeps", 8'h18, 32'h0000_0018);
    wr(8'h18, 32'h0000_0008);
    chk_reg("R8 one clears", 8'h18, 32'h0000_0010);
    chk("R8 irq drops", 32'(irq_o), 32'h0);

    // R9: clear collides with new rising edge on pin3
    pad_di = 32'h0;
    tick(); tick(); tick();
    chk_reg("R6 wrong direction", 8'h18, 32'h0000_0010);
    pad_di = 32'h0000_0008;
    tick(); tick();
    wr(8'h18, 32'h0000_0008);
    chk_reg("R9 edge wins", 8'h18, 32'h0000_0018);
    chk("R9 irq", 32'(irq_o), 32'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule